// File: doc/BRIEF.md
# Absolute to physical address mapper

This block turns an absolute address into a physical address for accesses made while virtual translation is switched off. It is the path a load, store or fetch takes when no translation table is looked up: the address bits alone choose the physical result and the region it lands in. The block registers its result, so a request presented with `in_valid` shows up one clock later on `out_valid`, together with the physical address, a region code and the access rights.

Three operating conditions select the mapping. The legacy flag marks a 32-bit architecture, where only the low 32 address bits count. The wide flag marks the 64-bit wide mode, where the address is cut down to the physical width. Otherwise the narrow mode is used, where the top two nibbles of the low word decide between ordinary memory, I/O space and firmware space. The firmware region is moved up to the top of the physical space. The physical width `PA_W` is a parameter. It must lie between 36 and 54.

Top module: `abs_phys_mapper`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R2: With `in_legacy` low and `in_wide` high, `out_phys` equals address bits [PA_W-1:0] and the region is memory (2'b00).
- R3: In narrow mode (both flags low), when address bits [31:28] differ from 4'hF, the region is memory (2'b00) and `out_phys` is the low 32 address bits with all higher bits zero.
- R4: In narrow mode, when bits [31:28] are 4'hF and bits [27:24] are not zero, the region is I/O (2'b01) and `out_phys` is the low 32 address bits with bit 31 copied into every higher bit.
- R5: In narrow mode, when bits [31:28] are 4'hF and bits [27:24] are zero, the region is firmware (2'b10) and `out_phys` is the low 32 bits zero-extended, with bits [PA_W-1:PA_W-4] forced to ones.
- R6: With `in_legacy` high, `out_phys` is the low 32 address bits zero-extended and the region is memory, whatever the upper address bits hold.
- R7: When `in_legacy` and `in_wide` are both high, the legacy mapping of R6 applies.
- R8: `out_rwx` is 3'b111 (read, write, execute granted) whenever `out_valid` is high, and 3'b000 otherwise.
- R9: A cycle with `in_valid` low leaves `out_phys` and `out_region` unchanged.
- R10: While `rst_n` is low at a clock edge, all outputs clear to zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 64 | Absolute address |
| in_wide | input | 1 | Wide mode selected |
| in_legacy | input | 1 | 32-bit architecture selected |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_phys | output | PA_W | Physical address |
| out_region | output | 2 | Region: 00 memory, 01 I/O, 10 firmware |
| out_rwx | output | 3 | Granted rights, bit 2 read, bit 1 write, bit 0 execute |

## Verification
The two mode flags may be set in the same cycle, which makes the legacy and wide mappings compete for one request. The bench drives every combination of the two flags against every value of address bits [31:24]. The upper address bits are random, so any leak of the wide truncation into a legacy request shows up as nonzero high bits. Each result is judged against an arithmetic model in which legacy wins, and the region code must read memory.

// File: rtl/abs_map_pkg.sv
// Shared types for the absolute to physical address mapper.
// Assumes nothing beyond a two-bit region code.
package abs_map_pkg;
    typedef enum logic [1:0] {
        REGION_MEM = 2'b00,
        REGION_IO  = 2'b01,
        REGION_FW  = 2'b10
    } region_e;

    localparam logic [3:0] HIGH_NIBBLE = 4'hF;
    localparam int         FW_TOP_BITS = 4;
    localparam int         WORD_W      = 32;
endpackage

// File: rtl/abs_narrow_decode.sv
// Narrow-mode decoder: classifies the low word into memory, I/O or
// firmware and extends it to PA_W bits. Assumes PA_W >= 36.
module abs_narrow_decode
    import abs_map_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic [WORD_W-1:0] word,
    output logic [PA_W-1:0]   pa,
    output region_e           region
);
    localparam int EXT_W = PA_W - WORD_W;

    logic in_top;
    logic sub_zero;

    // Region classification from the two top nibbles of the word.
    always_comb begin
        in_top   = (word[31:28] == HIGH_NIBBLE);
        sub_zero = (word[27:24] == 4'h0);
        if (!in_top)
            region = REGION_MEM;
        else if (!sub_zero)
            region = REGION_IO;
        else
            region = REGION_FW;
    end

    // Extension of the word according to the region.
    always_comb begin
        pa = {{EXT_W{1'b0}}, word};
        unique case (region)
            REGION_IO: pa = {{EXT_W{word[WORD_W-1]}}, word};
            REGION_FW: pa[PA_W-1 -: FW_TOP_BITS] = {FW_TOP_BITS{1'b1}};
            default:   pa = {{EXT_W{1'b0}}, word};
        endcase
    end
endmodule

// File: rtl/abs_wide_trunc.sv
// Wide-mode path: keeps the low PA_W address bits. Assumes PA_W < ADDR_W.
module abs_wide_trunc #(
    parameter int ADDR_W = 64,
    parameter int PA_W   = 40
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PA_W-1:0]   pa
);
    // Truncation to the implemented physical width.
    always_comb pa = addr[PA_W-1:0];
endmodule

// File: rtl/abs_out_stage.sv
// Output register: captures the result with its strobe; holds the
// address and region while no request arrives. Sync active-low reset.
module abs_out_stage
    import abs_map_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            d_valid,
    input  logic [PA_W-1:0] d_pa,
    input  region_e         d_region,
    output logic            q_valid,
    output logic [PA_W-1:0] q_pa,
    output logic [1:0]      q_region,
    output logic [2:0]      q_rwx
);
    // Strobe and rights follow the request every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_rwx   <= 3'b000;
        end else begin
            q_valid <= d_valid;
            q_rwx   <= {3{d_valid}};
        end
    end

    // Address and region load only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_pa     <= '0;
            q_region <= 2'b00;
        end else if (d_valid) begin
            q_pa     <= d_pa;
            q_region <= d_region;
        end
    end
endmodule

// File: rtl/abs_phys_mapper.sv
// Absolute to physical address mapper, top level. Selects between
// legacy, wide and narrow mappings (legacy first) and registers the
// result. Assumes 36 <= PA_W <= 54 and ADDR_W > PA_W.
module abs_phys_mapper
    import abs_map_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PA_W   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_wide,
    input  logic              in_legacy,
    output logic              out_valid,
    output logic [PA_W-1:0]   out_phys,
    output logic [1:0]        out_region,
    output logic [2:0]        out_rwx
);
    localparam int EXT_W = PA_W - WORD_W;

    logic [PA_W-1:0] narrow_pa;
    logic [PA_W-1:0] wide_pa;
    logic [PA_W-1:0] sel_pa;
    region_e         narrow_region;
    region_e         sel_region;

    abs_narrow_decode #(.PA_W(PA_W)) u_narrow (
        .word   (in_addr[WORD_W-1:0]),
        .pa     (narrow_pa),
        .region (narrow_region)
    );

    abs_wide_trunc #(.ADDR_W(ADDR_W), .PA_W(PA_W)) u_wide (
        .addr (in_addr),
        .pa   (wide_pa)
    );

    // Mode selection with legacy taking priority over wide.
    always_comb begin
        if (in_legacy) begin
            sel_pa     = {{EXT_W{1'b0}}, in_addr[WORD_W-1:0]};
            sel_region = REGION_MEM;
        end else if (in_wide) begin
            sel_pa     = wide_pa;
            sel_region = REGION_MEM;
        end else begin
            sel_pa     = narrow_pa;
            sel_region = narrow_region;
        end
    end

    abs_out_stage #(.PA_W(PA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_valid  (in_valid),
        .d_pa     (sel_pa),
        .d_region (sel_region),
        .q_valid  (out_valid),
        .q_pa     (out_phys),
        .q_region (out_region),
        .q_rwx    (out_rwx)
    );
endmodule

// File: rtl/abs_phys_mapper_chk.sv
// Checker for abs_phys_mapper, attached by bind. Observes ports only.
module abs_phys_mapper_chk #(
    parameter int ADDR_W = 64,
    parameter int PA_W   = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              in_wide,
    input logic              in_legacy,
    input logic              out_valid,
    input logic [PA_W-1:0]   out_phys,
    input logic [1:0]        out_region,
    input logic [2:0]        out_rwx
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_wide_trunc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_wide && !in_legacy) |=>
        (out_phys == $past(in_addr[PA_W-1:0]) && out_region == 2'b00));
    assert_fw_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_region == 2'b10) |-> (out_phys[PA_W-1 -: 4] == 4'hF));
    assert_legacy_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_legacy) |=>
        (out_phys[PA_W-1:32] == '0 && out_region == 2'b00));
    assert_rights_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_rwx == (out_valid ? 3'b111 : 3'b000));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_phys) && $stable(out_region)));
    assert_region_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_region != 2'b11);
endmodule

bind abs_phys_mapper abs_phys_mapper_chk #(.ADDR_W(ADDR_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_wide(in_wide), .in_legacy(in_legacy), .out_valid(out_valid),
    .out_phys(out_phys), .out_region(out_region), .out_rwx(out_rwx)
);

// File: tb/sim_abs_phys_mapper.sv
module sim_abs_phys_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 64;
    localparam int N  = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic          in_wide = 1'b0;
    logic          in_legacy = 1'b0;
    logic          out_valid;
    logic [N-1:0]  out_phys;
    logic [1:0]    out_region;
    logic [2:0]    out_rwx;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    abs_phys_mapper #(.ADDR_W(AW), .PA_W(N)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_wide(in_wide), .in_legacy(in_legacy), .out_valid(out_valid),
        .out_phys(out_phys), .out_region(out_region), .out_rwx(out_rwx)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Arithmetic model of the mapping.
    task automatic model(input logic [63:0] a, input logic w, input logic l,
                         output logic [N-1:0] pa, output logic [1:0] rg, output string req);
        logic [63:0] lo;
        lo = {32'h0, a[31:0]};
        rg = 2'b00;
        if (l) begin
            pa = lo[N-1:0]; req = w ? "R7" : "R6";
        end else if (w) begin
            pa = a[N-1:0]; req = "R2";
        end else if (a[31:28] != 4'hF) begin
            pa = lo[N-1:0]; req = "R3";
        end else if (a[27:24] != 4'h0) begin
            pa = lo[N-1:0] | (((64'd1 << N) - 1) & ~64'hFFFF_FFFF);
            rg = 2'b01; req = "R4";
        end else begin
            pa = lo[N-1:0] | (64'hF << (N - 4));
            rg = 2'b10; req = "R5";
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic w, input logic l);
        logic [N-1:0] pa;
        logic [1:0]   rg;
        string        req;
        model(a, w, l, pa, rg, req);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_wide = w; in_legacy = l;
        @(negedge clk);
        chk({req, " phys"}, 64'(out_phys), 64'(pa));
        chk({req, " region"}, 64'(out_region), 64'(rg));
        chk("R1 valid", 64'(out_valid), 64'd1);
        chk("R8 rights", 64'(out_rwx), 64'd7);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] held_pa;
        logic [1:0]   held_rg;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 valid", 64'(out_valid), 64'd0);
        chk("R10 phys", 64'(out_phys), 64'd0);
        chk("R10 region", 64'(out_region), 64'd0);
        chk("R10 rights", 64'(out_rwx), 64'd0);
        rst_n = 1'b1;

        // Corner cases.
        apply(64'h0000_0000_F000_0000, 1'b0, 1'b0);
        apply(64'h0000_0000_F0FF_FFFF, 1'b0, 1'b0);
        apply(64'h0000_0000_F100_0000, 1'b0, 1'b0);
        apply(64'h0000_0000_EFFF_FFFF, 1'b0, 1'b0);
        apply(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
        apply(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1);
        apply(64'hFFFF_FFFF_F000_0000, 1'b0, 1'b1);

        // Sweep every top byte under every mode pairing, random upper bits.
        for (int tb = 0; tb < 256; tb++) begin
            for (int m = 0; m < 4; m++) begin
                logic [63:0] a;
                a = {$urandom(), 8'(tb), 24'($urandom())};
                apply(a, m[0], m[1]);
            end
        end

        // R9 and R1: idle cycle holds the result and drops valid.
        apply(64'h1234_5678_F200_0042, 1'b0, 1'b0);
        held_pa = out_phys; held_rg = out_region;
        in_valid = 1'b0; in_addr = 64'h0; in_wide = 1'b1; in_legacy = 1'b0;
        @(negedge clk);
        chk("R9 phys held", 64'(out_phys), 64'(held_pa));
        chk("R9 region held", 64'(out_region), 64'(held_rg));
        chk("R1 valid low", 64'(out_valid), 64'd0);
        chk("R8 rights low", 64'(out_rwx), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule